// File: doc/BRIEF.md
# Saturated Switch-Count Controller for a Supply-Hopping Stage

This block sets how many parallel power switches feed a core supply rail. Once per sample it takes a signed code giving the voltage error and moves an integer switch count. The new count is the previous count plus a rounded term. That term is built from fixed-point gains, applied to the latest error and to the change since the previous error. The result is clamped so that the count stays between one and the number of switches. Because the count never reaches zero, the rail is never left without a path to the supply.

The error code first passes through a short input delay, so that the law sees samples aligned with the load clock. The computed count then passes through one more register before it leaves the block.

The count goes out in two forms: as a binary number and as a thermometer vector that drives the switch gates directly. A mode input replaces the gain law with a plain sign-stepping law, which moves the count by at most one per sample. The mode bit travels down the input delay together with its error sample.

Top module: `hop_switch_ctrl`

## Requirements
- R1: In gain mode the count changes by round(K1·(e − e_prev) + K2·e_prev). Here e is the delayed error code, e_prev is the error used by the previous update, and the gains are Q4.12 signed values (code/4096) with defaults of −2007 and 2949. Rounding goes to the nearest integer, and exact halves round away from zero.
- R2: The updated count is clamped to the range 1 to NSW (default 24). The sum is formed at full width, so a large step can never wrap past either limit.
- R3: Bit i of `sw_en` is 1 exactly when i is less than `sw_count`, so bit 0 is always 1.
- R4: An error code presented at clock edge t affects `sw_count` and `sw_en` first after edge t+3. The path has two input stages, the count register and one output stage.
- R5: When `step_mode` is 1 for a sample, the count changes by +1 for a positive error, −1 for a negative error and 0 for a zero error, under the same clamp.
- R6: While `rst` is high at a clock edge (synchronous reset), the count and every output stage load 1 (`sw_en` = 1). The stored previous error and the input delay stages load 0.
- R7: `step_mode` is delayed together with `err_in`, so each sample is processed under the mode that was presented with it.
- R8: A sample whose error and stored previous error are both zero leaves the count unchanged, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one update per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| err_in | input | EW (12) | Signed error code, reference minus measured |
| step_mode | input | 1 | 1 selects the sign-stepping law for this sample |
| sw_count | output | CW (5) | Number of switches on, binary |
| sw_en | output | NSW (24) | Thermometer-coded switch enables |

## Verification
Each sample is presented on a falling edge. Its effect on `sw_count` and `sw_en` is due after the fourth rising edge that follows: two input stages, the count register and the output stage. The scoreboard stamps every expected item with the cycle number at which it falls due. The monitor compares only in that cycle, one time unit after the rising edge. A design that is early or late by a single register therefore mismatches on every changing sample. A second instance with gains of 0 and exactly one half turns every odd previous error into an exact rounding tie, which checks that halves round away from zero. The reset checks are made while reset is held, and again after a release that follows a large stored error.

// File: rtl/hop_switch_ctrl.sv
module hop_switch_ctrl #(
  parameter int NSW = 24,
  parameter int EW = 12,
  parameter int GW = 16,
  parameter int GFRAC = 12,
  parameter logic signed [GW-1:0] K1 = -16'sd2007,
  parameter logic signed [GW-1:0] K2 = 16'sd2949,
  parameter int IN_DLY = 2,
  parameter int OUT_DLY = 1,
  localparam int CW = $clog2(NSW + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err_in,
  input  logic                 step_mode,
  output logic [CW-1:0]        sw_count,
  output logic [NSW-1:0]       sw_en
);
  localparam int DW = EW + 1;
  localparam int SW = GW + DW + 1;
  localparam logic [SW-1:0] HALF = SW'(1) << (GFRAC - 1);
  localparam logic signed [SW-1:0] ONE = SW'(1);
  localparam logic signed [SW:0] LO = (SW + 1)'(1);
  localparam logic signed [SW:0] HI = (SW + 1)'(NSW);

  logic signed [EW-1:0] epipe [IN_DLY];
  logic                 mpipe [IN_DLY];
  logic signed [EW-1:0] e_prev;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        ocnt [OUT_DLY];
  logic [NSW-1:0]       oen  [OUT_DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < IN_DLY; i++) begin
        epipe[i] <= '0;
        mpipe[i] <= 1'b0;
      end
    end else begin
      epipe[0] <= err_in;
      mpipe[0] <= step_mode;
      for (int i = 1; i < IN_DLY; i++) begin
        epipe[i] <= epipe[i-1];
        mpipe[i] <= mpipe[i-1];
      end
    end
  end

  logic signed [EW-1:0] e_k;
  logic                 mode_k;
  assign e_k    = epipe[IN_DLY-1];
  assign mode_k = mpipe[IN_DLY-1];

  logic signed [DW-1:0] diff;
  logic signed [SW-1:0] wsum, d_gain, d_step, d_sel;
  logic [SW-1:0]        mag, rmag;
  logic signed [SW:0]   sum_full;
  logic [CW-1:0]        cnt_nx;

  assign diff   = DW'(e_k) - DW'(e_prev);
  assign wsum   = SW'(K1) * SW'(diff) + SW'(K2) * SW'(e_prev);
  assign mag    = wsum[SW-1] ? SW'(-wsum) : SW'(wsum);
  assign rmag   = (mag + HALF) >> GFRAC;
  assign d_gain = wsum[SW-1] ? -$signed(rmag) : $signed(rmag);
  assign d_step = e_k[EW-1] ? -ONE : ((e_k != '0) ? ONE : '0);
  assign d_sel  = mode_k ? d_step : d_gain;
  assign sum_full = $signed({{(SW + 1 - CW){1'b0}}, cnt}) + (SW + 1)'(d_sel);

  always_comb begin
    if (sum_full < LO)      cnt_nx = CW'(1);
    else if (sum_full > HI) cnt_nx = CW'(NSW);
    else                    cnt_nx = CW'(sum_full);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= CW'(1);
      e_prev <= '0;
    end else begin
      cnt    <= cnt_nx;
      e_prev <= e_k;
    end
  end

  logic [NSW-1:0] therm;
  always_comb begin
    for (int i = 0; i < NSW; i++) therm[i] = (CW'(i) < cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < OUT_DLY; i++) begin
        ocnt[i] <= CW'(1);
        oen[i]  <= NSW'(1);
      end
    end else begin
      ocnt[0] <= cnt;
      oen[0]  <= therm;
      for (int i = 1; i < OUT_DLY; i++) begin
        ocnt[i] <= ocnt[i-1];
        oen[i]  <= oen[i-1];
      end
    end
  end

  assign sw_count = ocnt[OUT_DLY-1];
  assign sw_en    = oen[OUT_DLY-1];
endmodule

module hop_switch_ctrl_chk #(
  parameter int NSW = 24,
  parameter int EW = 12,
  parameter int CW = 5,
  parameter int OUT_DLY = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CW-1:0]        sw_count,
  input logic [NSW-1:0]       sw_en,
  input logic [CW-1:0]        cnt,
  input logic                 mode_k,
  input logic signed [EW-1:0] e_k,
  input logic signed [EW-1:0] e_prev
);
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    (cnt >= CW'(1)) && (cnt <= CW'(NSW)) && (sw_count >= CW'(1)) && (sw_count <= CW'(NSW)));

  a_r3_therm_match: assert property (@(posedge clk) disable iff (rst)
    sw_en[0] && (((sw_en + NSW'(1)) & sw_en) == '0) && ($countones(sw_en) == int'(sw_count)));

  a_r5_step_unit: assert property (@(posedge clk) disable iff (rst)
    mode_k |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1)));

  a_r8_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (e_k == '0 && e_prev == '0) |=> (cnt == $past(cnt)));

  a_r6_reset_state: assert property (@(posedge clk)
    rst |=> (cnt == CW'(1)) && (sw_count == CW'(1)) && (sw_en == NSW'(1)) && (e_prev == '0));

  generate
    if (OUT_DLY == 1) begin : g_one_stage
      a_r4_out_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sw_count == $past(cnt)));
    end
  endgenerate
endmodule

bind hop_switch_ctrl hop_switch_ctrl_chk #(
  .NSW(NSW), .EW(EW), .CW(CW), .OUT_DLY(OUT_DLY)
) u_chk (
  .clk(clk), .rst(rst), .sw_count(sw_count), .sw_en(sw_en),
  .cnt(cnt), .mode_k(mode_k), .e_k(e_k), .e_prev(e_prev)
);

// File: tb/hop_switch_ctrl_tb.sv
module hop_switch_ctrl_tb;
  localparam int NSW = 24;
  localparam int CW = 5;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [11:0] err_in = '0;
  logic step_mode = 1'b0;
  logic [CW-1:0] cnt_d, cnt_h;
  logic [NSW-1:0] en_d, en_h;

  always #2 clk = ~clk;

  hop_switch_ctrl u_dut (
    .clk(clk), .rst(rst), .err_in(err_in), .step_mode(step_mode),
    .sw_count(cnt_d), .sw_en(en_d));

  hop_switch_ctrl #(.K1(16'sd0), .K2(16'sd2048)) u_dut_half (
    .clk(clk), .rst(rst), .err_in(err_in), .step_mode(step_mode),
    .sw_count(cnt_h), .sw_en(en_h));

  typedef struct {
    int    due;
    int    val;
    int    inst;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int mdl [2];
  int pep [2];
  int gk1 [2] = '{-2007, 0};
  int gk2 [2] = '{2949, 2048};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int law(int k1, int k2, int e, int ep, bit m, int cur);
    int s, r, n;
    if (m) r = (e > 0) ? 1 : ((e < 0) ? -1 : 0);
    else begin
      s = k1 * (e - ep) + k2 * ep;
      r = (s >= 0) ? (s + 2048) / 4096 : -((2048 - s) / 4096);
    end
    n = cur + r;
    if (n < 1) n = 1;
    if (n > NSW) n = NSW;
    return n;
  endfunction

  function automatic logic [NSW-1:0] therm_of(int c);
    logic [NSW-1:0] t;
    for (int i = 0; i < NSW; i++) t[i] = (i < c);
    return t;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic drive(int e, bit m, string tag);
    @(negedge clk);
    err_in = 12'(e);
    step_mode = m;
    for (int i = 0; i < 2; i++) begin
      mdl[i] = law(gk1[i], gk2[i], e, pep[i], m, mdl[i]);
      pep[i] = e;
      q.push_back('{cyc + LAT, mdl[i], i, tag});
    end
  endtask

  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.inst == 0) begin
        check({it.tag, " count"}, int'(cnt_d), it.val);
        n_chk++;
        if (en_d !== therm_of(it.val)) begin
          n_bad++;
          $display("FAIL R3 (%s) enables: actual %h expected %h", it.tag, en_d, therm_of(it.val));
        end
      end else begin
        check({it.tag, " half-gain count"}, int'(cnt_h), it.val);
      end
    end
  end

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    err_in = '0;
    step_mode = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    check({tag, " reset count"}, int'(cnt_d), 1);
    check({tag, " reset enables"}, int'(en_d), 1);
    check({tag, " reset half count"}, int'(cnt_h), 1);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin
      mdl[i] = 1;
      pep[i] = 0;
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(0, 1'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset("R6");
    idle(6, "R8");

    // R4: single pulse, every cycle around it compared at its due slot
    drive(40, 1'b0, "R4");
    idle(5, "R4");

    // R1: assorted small errors through the gain law
    drive(100, 1'b0, "R1"); drive(100, 1'b0, "R1"); drive(-50, 1'b0, "R1");
    drive(300, 1'b0, "R1"); drive(7, 1'b0, "R1");  drive(-7, 1'b0, "R1");
    for (int i = 0; i < 12; i++) drive((i * 37) % 200 - 90, 1'b0, "R1");
    idle(4, "R1");

    // R1 ties: odd previous errors give exact halves on the half-gain instance
    drive(1, 1'b0, "R1 tie");  drive(0, 1'b0, "R1 tie");
    drive(-1, 1'b0, "R1 tie"); drive(0, 1'b0, "R1 tie");
    drive(3, 1'b0, "R1 tie");  drive(0, 1'b0, "R1 tie");
    drive(-3, 1'b0, "R1 tie"); drive(0, 1'b0, "R1 tie");
    drive(5, 1'b0, "R1 tie");  drive(5, 1'b0, "R1 tie");
    idle(4, "R1 tie");

    // R2: large errors saturate at both ends without wrap
    for (int i = 0; i < 4; i++) drive(2047, 1'b0, "R2 high");
    for (int i = 0; i < 4; i++) drive(-2048, 1'b0, "R2 low");
    drive(2047, 1'b0, "R2 swing"); drive(-2048, 1'b0, "R2 swing");
    idle(4, "R2");

    // R5: sign stepping up to the top clamp and back down
    for (int i = 0; i < 30; i++) drive(9, 1'b1, "R5 up");
    drive(0, 1'b1, "R5 zero");
    for (int i = 0; i < 30; i++) drive(-1, 1'b1, "R5 down");
    drive(0, 1'b1, "R5 zero");

    // R7: mode flips on every sample, each sample uses its own law
    for (int i = 0; i < 16; i++) drive((i % 2 == 0) ? 400 : -150, bit'(i % 2), "R7");
    idle(6, "R8");

    // R6: reset after a large stored error; a zero sample must not move the count
    drive(2047, 1'b0, "R2");
    drive(-2048, 1'b0, "R2");
    do_reset("R6 midrun");
    idle(8, "R6 prev cleared");

    repeat (LAT + 2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule